// File: doc/BRIEF.md
# Tiled Matrix-Vector Layer with Fused ReLU

This engine computes one dense layer of a small classifier network: every output element is the ReLU of the dot product between one weight row and a shared input vector. The engine works out of a bounded local scratchpad. It first asks an outside data mover for the input vector and keeps that vector in its own registers for the whole layer. It then asks for the weight rows a batch at a time. The batch size is the largest row count whose working set, counted in 32-bit words, fits the configured scratchpad byte budget.

Each weight request states the first row and the exact number of words wanted. The engine waits, for as many cycles as needed, until that many words have arrived on a plain valid-qualified word stream. It then runs the dot products of the batch one multiply-accumulate per cycle. Each finished sum goes through ReLU before it is written into a result bank that holds one word per output row. Only after the last batch, which may be shorter than the others, does the engine raise its completion pulse. From then on the whole hidden vector can be read through an index port.

The defaults (10 rows, 16 columns, 260 bytes) keep the stored arrays small. A full-sized 128×784 layer with a 32 KB budget is set through the parameters alone.

Top module: `tiled_mv_relu`

## Requirements
- R1: In the first cycle after an accepted start, the engine issues exactly one input-vector request: `fetchReq`=1, `fetchWeights`=0, `fetchLen`=COLS. This is the only input-vector request in the whole run.
- R2: The batch size is NB = floor((SPM_BYTES/4 − COLS − 1) / COLS), which is 3 for the defaults. Each weight request has `fetchWeights`=1, `fetchRow` equal to the first row of the batch, and `fetchLen` = rows_in_batch × COLS. Batches go in ascending row order, starting at row 0.
- R3: When ROWS is not a multiple of NB, the final batch carries ROWS mod NB rows. With the defaults, the batches carry 3, 3, 3 and 1 rows.
- R4: A word is consumed only in a cycle where `dataValid`=1 while the engine is waiting for requested words. Idle gaps of any length between words stall the engine without changing any result.
- R5: Words presented with `dataValid`=1 while no requested words are outstanding are ignored. This covers idle, the request cycle itself, and compute. Such words do not change any result.
- R6: Result row r equals the signed 32-bit sum over c of W[r][c]·x[c], with products and sums wrapping modulo 2^32. The weights are delivered row-major, column 0 first within each row. The input vector is delivered element 0 first.
- R7: ReLU is applied on write-back. A negative sum is stored as 0, and a zero or positive sum is stored unchanged.
- R8: `done` is a single-cycle pulse. It comes exactly rows_in_final_batch × COLS + 1 cycles after the cycle in which the last word of the final batch was presented. It never comes earlier. `outValid` is 1 from the cycle after `done` until a new start is accepted, and is 0 after reset.
- R9: A `start` pulse while the engine is busy is ignored, and the run in progress continues unchanged.
- R10: After reset, `busy`, `done`, `fetchReq` and `outValid` are 0. `busy` rises in the cycle after an accepted start and stays 1 up to and including the `done` cycle.
- R11: Row r of the result is readable on `resData` in the same cycle as `resIdx`=r. Results hold their values after completion until a new run overwrites them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a layer run (taken only when idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| outValid | output | 1 | Whole hidden vector is final and readable |
| fetchReq | output | 1 | One-cycle request for a block of words |
| fetchWeights | output | 1 | 0: input vector request, 1: weight rows request |
| fetchRow | output | $clog2(ROWS+1) | First weight row of the requested batch |
| fetchLen | output | $clog2(NB*COLS+1) | Number of words requested |
| dataValid | input | 1 | `dataWord` carries a word this cycle |
| dataWord | input | 32 | Incoming input-vector or weight word |
| resIdx | input | $clog2(ROWS+1) | Result row to read |
| resData | output | 32 | ReLU result of row `resIdx` |

## Verification
The properties assume the word source never presents more words than were requested. They also assume it presents no word in a waiting phase that belongs to a later request. Because of these assumptions, a request's length is enough to bound the phase that follows it. The bench source queues exactly the words named by each request. It starts delivering one cycle after it sees the request and inserts idle gaps between words. It drives junk words only while its queue is empty or in the request cycle itself, which are exactly the windows the engine must ignore. A start pulse in the middle of a run is also applied, to confirm that it has no effect.

// File: rtl/tmv_pkg.sv
package tmv_pkg;

  localparam int unsigned DATA_W = 32;

  typedef logic signed [DATA_W-1:0] word_t;

  // control phases of one layer run
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_REQX,
    PH_LOADX,
    PH_REQW,
    PH_FILL,
    PH_CALC,
    PH_FIN
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadX;   // write dataWord into the input-vector registers
    logic loadW;   // write dataWord into the weight scratchpad
    logic mac;     // accumulate one product
    logic commit;  // last column: write relu(sum) and clear the accumulator
  } dp_strobe_t;

  function automatic word_t reluClip(word_t v);
    return v[DATA_W-1] ? '0 : v;
  endfunction

endpackage

// File: rtl/tmv_datapath.sv
module tmv_datapath
  import tmv_pkg::*;
#(
  parameter int unsigned ROWS  = 10,
  parameter int unsigned COLS  = 16,
  parameter int unsigned BATCH = 3,
  parameter int unsigned LENW  = 6,
  parameter int unsigned ROWW  = 4,
  parameter int unsigned RIW   = 2,
  parameter int unsigned COLW  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_strobe_t       strobe,
  input  logic [LENW-1:0]  wrIdx,
  input  logic [RIW-1:0]   macRow,
  input  logic [COLW-1:0]  macCol,
  input  logic [ROWW-1:0]  resRow,
  input  word_t            dataWord,
  input  logic [ROWW-1:0]  resIdx,
  output word_t            resData
);

  localparam int unsigned SPM_DEPTH = BATCH * COLS;
  localparam int unsigned SPMW      = (SPM_DEPTH > 1) ? $clog2(SPM_DEPTH) : 1;

  // input vector held in flops, one element per generate slice
  logic [COLS*DATA_W-1:0] xFlat;

  for (genvar g = 0; g < COLS; g++) begin : gXreg
    word_t q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                   q <= '0;
      else if (strobe.loadX && wrIdx == LENW'(g))  q <= dataWord;
    end
    assign xFlat[g*DATA_W +: DATA_W] = q;
  end

  // weight scratchpad for one batch, row-major
  word_t spm [SPM_DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.loadW) spm[SPMW'(wrIdx)] <= dataWord;
  end

  logic [SPMW-1:0] spmAddr;
  word_t           spmRd;
  word_t           xRd;
  word_t           prod;
  word_t           acc;
  word_t           nextSum;

  always_comb begin
    spmAddr = SPMW'(32'(macRow) * COLS + 32'(macCol));
    spmRd   = spm[spmAddr];
    xRd     = word_t'(xFlat[32'(macCol)*DATA_W +: DATA_W]);
    prod    = spmRd * xRd;
    nextSum = acc + prod;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              acc <= '0;
    else if (strobe.commit) acc <= '0;
    else if (strobe.mac)    acc <= nextSum;
  end

  // hidden-layer result bank
  word_t resMem [ROWS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ROWS; i++) resMem[i] <= '0;
    end else if (strobe.commit) begin
      resMem[resRow] <= reluClip(nextSum);
    end
  end

  assign resData = (resIdx < ROWW'(ROWS)) ? resMem[resIdx] : '0;

endmodule

// File: rtl/tmv_control.sv
module tmv_control
  import tmv_pkg::*;
#(
  parameter int unsigned ROWS  = 10,
  parameter int unsigned COLS  = 16,
  parameter int unsigned BATCH = 3,
  parameter int unsigned LENW  = 6,
  parameter int unsigned ROWW  = 4,
  parameter int unsigned RIW   = 2,
  parameter int unsigned COLW  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             dataValid,
  output logic             busy,
  output logic             done,
  output logic             outValid,
  output logic             fetchReq,
  output logic             fetchWeights,
  output logic [ROWW-1:0]  fetchRow,
  output logic [LENW-1:0]  fetchLen,
  output dp_strobe_t       strobe,
  output logic [LENW-1:0]  wrIdx,
  output logic [RIW-1:0]   macRow,
  output logic [COLW-1:0]  macCol,
  output logic [ROWW-1:0]  resRow
);

  phase_e          phase;
  logic [LENW-1:0] wordCnt;
  logic [ROWW-1:0] batchBase;
  logic [RIW-1:0]  rowIdx;
  logic [COLW-1:0] colIdx;
  logic            outQ;

  logic [ROWW-1:0] remaining;
  logic [RIW-1:0]  batchRows;
  logic [LENW-1:0] batchLen;
  logic            lastCol;
  logic            lastRow;
  logic            lastBatch;
  logic            lastXWord;
  logic            lastWWord;

  always_comb begin
    remaining = ROWW'(ROWS) - batchBase;
    batchRows = (32'(remaining) > BATCH) ? RIW'(BATCH) : RIW'(remaining);
    batchLen  = LENW'(32'(batchRows) * COLS);
    lastCol   = (colIdx == COLW'(COLS - 1));
    lastRow   = (rowIdx == batchRows - RIW'(1));
    lastBatch = (32'(batchBase) + 32'(batchRows)) >= ROWS;
    lastXWord = (wordCnt == LENW'(COLS - 1));
    lastWWord = (wordCnt == batchLen - LENW'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      wordCnt   <= '0;
      batchBase <= '0;
      rowIdx    <= '0;
      colIdx    <= '0;
      outQ      <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_REQX;
            outQ  <= 1'b0;
          end
        end
        PH_REQX: begin
          phase   <= PH_LOADX;
          wordCnt <= '0;
        end
        PH_LOADX: begin
          if (dataValid) begin
            wordCnt <= wordCnt + LENW'(1);
            if (lastXWord) begin
              phase     <= PH_REQW;
              batchBase <= '0;
            end
          end
        end
        PH_REQW: begin
          phase   <= PH_FILL;
          wordCnt <= '0;
        end
        PH_FILL: begin
          if (dataValid) begin
            wordCnt <= wordCnt + LENW'(1);
            if (lastWWord) begin
              phase  <= PH_CALC;
              rowIdx <= '0;
              colIdx <= '0;
            end
          end
        end
        PH_CALC: begin
          if (lastCol) begin
            colIdx <= '0;
            if (lastRow) begin
              if (lastBatch) begin
                phase <= PH_FIN;
              end else begin
                batchBase <= batchBase + ROWW'(batchRows);
                phase     <= PH_REQW;
              end
            end else begin
              rowIdx <= rowIdx + RIW'(1);
            end
          end else begin
            colIdx <= colIdx + COLW'(1);
          end
        end
        PH_FIN: begin
          outQ  <= 1'b1;
          phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    busy          = (phase != PH_IDLE);
    done          = (phase == PH_FIN);
    outValid      = outQ;
    fetchReq      = (phase == PH_REQX) || (phase == PH_REQW);
    fetchWeights  = (phase == PH_REQW);
    fetchRow      = (phase == PH_REQW) ? batchBase : '0;
    fetchLen      = (phase == PH_REQW) ? batchLen : LENW'(COLS);
    strobe.loadX  = (phase == PH_LOADX) && dataValid;
    strobe.loadW  = (phase == PH_FILL) && dataValid;
    strobe.mac    = (phase == PH_CALC);
    strobe.commit = (phase == PH_CALC) && lastCol;
    wrIdx         = wordCnt;
    macRow        = rowIdx;
    macCol        = colIdx;
    resRow        = batchBase + ROWW'(rowIdx);
  end

endmodule

// File: rtl/tiled_mv_relu.sv
module tiled_mv_relu
  import tmv_pkg::*;
#(
  parameter  int unsigned ROWS      = 10,
  parameter  int unsigned COLS      = 16,
  parameter  int unsigned SPM_BYTES = 260,
  localparam int unsigned SPM_WORDS = SPM_BYTES / 4,
  localparam int unsigned BATCH     = (SPM_WORDS - COLS - 1) / COLS,
  localparam int unsigned LENW      = $clog2(BATCH * COLS + 1),
  localparam int unsigned ROWW      = $clog2(ROWS + 1),
  localparam int unsigned RIW       = $clog2(BATCH + 1),
  localparam int unsigned COLW      = $clog2(COLS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  output logic                busy,
  output logic                done,
  output logic                outValid,
  output logic                fetchReq,
  output logic                fetchWeights,
  output logic [ROWW-1:0]     fetchRow,
  output logic [LENW-1:0]     fetchLen,
  input  logic                dataValid,
  input  logic [DATA_W-1:0]   dataWord,
  input  logic [ROWW-1:0]     resIdx,
  output logic [DATA_W-1:0]   resData
);

  dp_strobe_t      strobe;
  logic [LENW-1:0] wrIdx;
  logic [RIW-1:0]  macRow;
  logic [COLW-1:0] macCol;
  logic [ROWW-1:0] resRow;
  word_t           resWord;

  tmv_control #(
    .ROWS(ROWS), .COLS(COLS), .BATCH(BATCH),
    .LENW(LENW), .ROWW(ROWW), .RIW(RIW), .COLW(COLW)
  ) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .dataValid    (dataValid),
    .busy         (busy),
    .done         (done),
    .outValid     (outValid),
    .fetchReq     (fetchReq),
    .fetchWeights (fetchWeights),
    .fetchRow     (fetchRow),
    .fetchLen     (fetchLen),
    .strobe       (strobe),
    .wrIdx        (wrIdx),
    .macRow       (macRow),
    .macCol       (macCol),
    .resRow       (resRow)
  );

  tmv_datapath #(
    .ROWS(ROWS), .COLS(COLS), .BATCH(BATCH),
    .LENW(LENW), .ROWW(ROWW), .RIW(RIW), .COLW(COLW)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrIdx    (wrIdx),
    .macRow   (macRow),
    .macCol   (macCol),
    .resRow   (resRow),
    .dataWord (word_t'(dataWord)),
    .resIdx   (resIdx),
    .resData  (resWord)
  );

  assign resData = resWord;

endmodule

// File: rtl/tmv_checker.sv
module tmv_checker #(
  parameter int unsigned COLS  = 16,
  parameter int unsigned BATCH = 3,
  parameter int unsigned LENW  = 6,
  parameter int unsigned ROWW  = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            outValid,
  input logic            fetchReq,
  input logic            fetchWeights,
  input logic [LENW-1:0] fetchLen,
  input logic [ROWW-1:0] resIdx,
  input logic [31:0]     resData
);

  // R10: an accepted start makes the engine busy on the next cycle
  a_r10_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy);

  // R10: requests are only issued during a run
  a_r10_req_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> busy);

  // R8: completion lasts exactly one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: the result becomes valid and the engine idle right after completion
  a_r8_valid_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> outValid && !busy);

  // R1: the first cycle of a run requests the input vector
  a_r1_first_fetch_input: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> fetchReq && !fetchWeights && fetchLen == LENW'(COLS));

  // R2: weight requests are whole rows and fit the batch
  a_r2_weight_len: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && fetchWeights |->
      (32'(fetchLen) % COLS == 0) && (fetchLen != '0) && (32'(fetchLen) <= BATCH * COLS));

  // R9: once busy, the engine stays busy until it completes, start or not
  a_r9_busy_until_done: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done |=> busy);

  // R11: valid results hold while the read index holds
  a_r11_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !start |=> (!$stable(resIdx) || $stable(resData)));

endmodule

bind tiled_mv_relu tmv_checker #(
  .COLS(COLS), .BATCH(BATCH), .LENW(LENW), .ROWW(ROWW)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .outValid     (outValid),
  .fetchReq     (fetchReq),
  .fetchWeights (fetchWeights),
  .fetchLen     (fetchLen),
  .resIdx       (resIdx),
  .resData      (resData)
);

// File: tb/tiled_mv_relu_tb_top.sv
module tiled_mv_relu_tb_top;

  localparam int ROWS      = 10;
  localparam int COLS      = 16;
  localparam int SPM_BYTES = 260;
  localparam int NB        = (SPM_BYTES / 4 - COLS - 1) / COLS;
  localparam int ROWW      = $clog2(ROWS + 1);
  localparam int LENW      = $clog2(NB * COLS + 1);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            start = 1'b0;
  logic            dataValid = 1'b0;
  logic [31:0]     dataWord = '0;
  logic [ROWW-1:0] resIdx = '0;
  logic            busy, done, outValid, fetchReq, fetchWeights;
  logic [ROWW-1:0] fetchRow;
  logic [LENW-1:0] fetchLen;
  logic [31:0]     resData;

  always #10 clk = ~clk;   // 50 MHz

  tiled_mv_relu #(.ROWS(ROWS), .COLS(COLS), .SPM_BYTES(SPM_BYTES)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .outValid(outValid), .fetchReq(fetchReq), .fetchWeights(fetchWeights),
    .fetchRow(fetchRow), .fetchLen(fetchLen), .dataValid(dataValid),
    .dataWord(dataWord), .resIdx(resIdx), .resData(resData)
  );

  int tests = 0;
  int fails = 0;

  task automatic check(bit ok, string tag, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // stimulus data and reference model state
  int  xv [COLS];
  int  mm [ROWS][COLS];
  int  pend [$];
  bit  justReq = 0, startPending = 0, prevAccept = 0, prevDone = 0;
  bit  expBusy = 0, expOut = 0, xSeen = 0, runFinished = 0, finalPending = 0;
  int  cyc = 0, expDoneCyc = -1, nextRow = 0, finalRows = 0;
  int  gapK = 0;
  bit  junkOn = 0;

  // cycle-by-cycle model, word source and comparison
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (prevAccept) begin
        expBusy = 1; expOut = 0; xSeen = 0; nextRow = 0;
      end
      if (prevDone) begin
        expBusy = 0; expOut = 1;
      end
      check(busy == expBusy, "R10 busy", busy, expBusy);
      check(outValid == expOut, "R8 outValid", outValid, expOut);
      check(done == (cyc == expDoneCyc), "R8 done timing", done, cyc == expDoneCyc);
      if (fetchReq) begin
        if (!xSeen) begin
          check(!fetchWeights, "R1 kind", fetchWeights, 0);
          check(int'(fetchLen) == COLS, "R1 length", fetchLen, COLS);
          xSeen = 1;
          for (int c = 0; c < COLS; c++) pend.push_back(xv[c]);
        end else begin
          int rows;
          rows = (ROWS - nextRow > NB) ? NB : ROWS - nextRow;
          check(fetchWeights, "R2 kind", fetchWeights, 1);
          check(int'(fetchRow) == nextRow, "R2 row", fetchRow, nextRow);
          if (rows < NB) check(int'(fetchLen) == rows * COLS, "R3 short batch", fetchLen, rows * COLS);
          else           check(int'(fetchLen) == rows * COLS, "R2 batch length", fetchLen, rows * COLS);
          for (int r = 0; r < rows; r++)
            for (int c = 0; c < COLS; c++) pend.push_back(mm[nextRow + r][c]);
          nextRow += rows;
          if (nextRow >= ROWS) begin finalPending = 1; finalRows = rows; end
        end
        justReq = 1;
      end
      prevDone = done;
      if (done) runFinished = 1;
      // drive next inputs
      prevAccept   = startPending && !expBusy;
      start        = startPending;
      startPending = 0;
      if (pend.size() > 0 && !justReq && (gapK == 0 || cyc % gapK != 0)) begin
        dataValid = 1'b1;
        dataWord  = pend.pop_front();
        if (pend.size() == 0 && finalPending) begin
          expDoneCyc   = cyc + finalRows * COLS + 1;
          finalPending = 0;
        end
      end else if (junkOn && (pend.size() == 0 || justReq)) begin
        dataValid = 1'b1;
        dataWord  = $urandom;
      end else begin
        dataValid = 1'b0;
      end
      justReq = 0;
    end
  end

  task automatic runLayer(bit midStart);
    startPending = 1;
    if (midStart) begin
      repeat (40) @(negedge clk);
      startPending = 1;   // R9: ignored while busy
    end
    wait (runFinished == 1);
    runFinished = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic verify(string tag);
    for (int r = 0; r < ROWS; r++) begin
      int acc;
      acc = 0;
      for (int c = 0; c < COLS; c++) acc += mm[r][c] * xv[c];
      if (acc < 0) acc = 0;
      @(negedge clk);
      resIdx = ROWW'(r);
      #2;
      check(resData == acc, tag, $signed(resData), acc);
    end
  endtask

  initial begin
    int ex [9];
    ex = '{3, -42, 432, 7, -5, 6, 5, -114, 2};
    repeat (3) @(negedge clk);
    check(busy == 0, "R10 reset busy", busy, 0);
    check(done == 0, "R10 reset done", done, 0);
    check(fetchReq == 0, "R10 reset fetchReq", fetchReq, 0);
    check(outValid == 0, "R8 reset outValid", outValid, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // A: unit input selects column 0; ReLU of a signed example list (R7, R6)
    for (int c = 0; c < COLS; c++) xv[c] = (c == 0) ? 1 : 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        mm[r][c] = (c == 0) ? ((r < 9) ? ex[r] : 0) : int'($urandom_range(0, 50)) - 25;
    runLayer(0);
    verify("R7 relu example");

    // B: random small signed data, gaps, junk words, start while busy (R4, R5, R9)
    gapK = 3; junkOn = 1;
    for (int c = 0; c < COLS; c++) xv[c] = int'($urandom_range(0, 200)) - 100;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) mm[r][c] = int'($urandom_range(0, 200)) - 100;
    runLayer(1);
    verify("R4 R9 stalled run result");
    repeat (30) @(negedge clk);
    verify("R5 R11 junk while idle");

    // C: large values that wrap, plus a row that sums to exactly zero (R6, R7)
    gapK = 0;
    for (int c = 0; c < COLS; c++) xv[c] = 32'h4000_0000 + c * 32'h0123_4567;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) mm[r][c] = int'($urandom);
    for (int c = 0; c < COLS; c++) xv[c] = (c < 2) ? xv[c] : xv[c];
    for (int c = 0; c < COLS; c++) mm[ROWS-1][c] = 0;
    mm[ROWS-1][0] = 5; mm[ROWS-1][1] = 0;
    xv[0] = 0;
    runLayer(0);
    verify("R6 wrapping sums");

    // D: rerun with new data overwrites every row (R11)
    for (int c = 0; c < COLS; c++) xv[c] = c + 1;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) mm[r][c] = (r % 2 == 0) ? r - c : c - r;
    runLayer(0);
    verify("R11 rerun result");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule